// File: doc/BRIEF.md
# Five-Bit Bidirectional I/O Port

This block is a register-mapped general-purpose port of five pins. Each pin has a bit in an output-value register and a bit in a direction register. The block produces per-pin drive-value and drive-enable signals for the pad ring. Pad levels come back in through a two-flop synchronizer. A read of the port address returns those synchronized levels, not the register contents.

A bus master reaches three registers through a select, a write strobe, a two-bit address and a two-bit operation code. The operation is a whole-byte load, a single-bit set or a single-bit clear. A bit set or clear on the port register is a read-modify-write. The synchronized pin levels are read, one bit is changed, and all five bits go into the output latch.

The top pin is open-drain: it can only pull low. Its synchronized level is also sent out as a clock for an external timer. A two-bit mode field marks some of the low pins as analog. Reads of those pins return zero, while their drivers stay under the direction register.

The block has no sequencing state. Every access completes in the cycle it is strobed, so there are no states or transitions to name.

Top module: `gpio5_port`

## Requirements
- R1: After reset, the direction register holds all ones (every pin an input, every `pad_oe` low), the output latch is 0, and the analog mode is 00.
- R2: For pins 3..0, a direction bit of 1 deasserts `pad_oe`. A direction bit of 0 asserts `pad_oe` and drives the latch bit on `pad_out`.
- R3: A read of address 0 returns the pad levels through a two-flop synchronizer. A level present before clock edge n is returned from edge n+2 onward. Bits 7..5 read 0.
- R4: A load (op 00) to address 0 stores `bus_wdata[4:0]` in the latch, whatever the pin levels are.
- R5: A set (op 01) or clear (op 10) to address 0 with bit index 0..4 stores the current address-0 read value, with the indexed bit forced to 1 or 0. This overwrites latch bits of the other pins with their sampled levels.
- R6: Pin 4 is open-drain. `pad_out[4]` is always 0, and `pad_oe[4]` is high only when direction bit 4 is 0 and latch bit 4 is 0.
- R7: `tmr_clk` equals the synchronized level of pin 4, regardless of direction or analog mode.
- R8: Address 1 is the direction register. Its bits 7..5 always read 0, and writes to them are ignored.
- R9: Analog mode (address 2, bits 1..0) selects which pins read as 0 at address 0: 00 covers pins 3..0, 01 covers pins 1..0, 10 covers pin 0, and 11 covers none. The direction register still controls `pad_oe` for analog pins.
- R10: A set or clear to address 1 changes only the indexed direction bit. A bit index of 5..7 leaves the addressed register unchanged.
- R11: Address 2 is changed only by a load. Its read returns the mode in bits 1..0 with zeros above. Address 3 reads 0 and ignores writes. Op 11 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 2 | 0 port, 1 direction, 2 analog mode, 3 unused |
| bus_op | input | 2 | 00 load byte, 01 set bit, 10 clear bit, 11 none |
| bus_bit | input | 3 | Bit index for set and clear |
| bus_wdata | input | 8 | Write data for loads |
| bus_rdata | output | 8 | Read data for the addressed register |
| pad_in | input | 5 | Raw pad levels |
| pad_out | output | 5 | Per-pin drive value |
| pad_oe | output | 5 | Per-pin drive enable |
| tmr_clk | output | 1 | Synchronized pin-4 level for an external timer |

## Verification
A read-modify-write bit operation and a pad-level change can fall in the same cycle. In that case the new level is still in the first synchronizer flop when the write is captured. The bench changes a pad level in the same cycle that it strobes a port bit-set. It then turns every pin to output and checks `pad_out`, which must show the older sampled level in the latch rather than the new one.

// File: rtl/gpio5_pkg.sv
package gpio5_pkg;

    localparam int ANA_W = 4;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_SET  = 2'b01,
        OP_CLR  = 2'b10,
        OP_NONE = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        ANA_LOW4 = 2'b00,
        ANA_LOW2 = 2'b01,
        ANA_LOW1 = 2'b10,
        ANA_NONE = 2'b11
    } ana_mode_e;

    localparam logic [1:0] ADDR_PORT = 2'd0;
    localparam logic [1:0] ADDR_DIR  = 2'd1;
    localparam logic [1:0] ADDR_ANA  = 2'd2;

    function automatic logic [ANA_W-1:0] ana_mask(input ana_mode_e m);
        unique case (m)
            ANA_LOW4: ana_mask = 4'b1111;
            ANA_LOW2: ana_mask = 4'b0011;
            ANA_LOW1: ana_mask = 4'b0001;
            ANA_NONE: ana_mask = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/gpio5_sync.sv
module gpio5_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) st[k] <= '0;
        end else begin
            st[0] <= d;
            for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio5_regs.sv
module gpio5_regs
    import gpio5_pkg::*;
#(
    parameter int PW    = 5,
    parameter int REG_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [1:0]                 bus_addr,
    input  logic [1:0]                 bus_op,
    input  logic [$clog2(REG_W)-1:0]   bus_bit,
    input  logic [REG_W-1:0]           bus_wdata,
    input  logic [PW-1:0]              port_rd,
    output logic [PW-1:0]              latch_q,
    output logic [PW-1:0]              dir_q,
    output ana_mode_e                  ana_q,
    output logic [REG_W-1:0]           bus_rdata
);
    localparam int IDX_W = $clog2(REG_W);
    localparam logic [IDX_W-1:0] PW_IDX = IDX_W'(PW);

    bus_op_e     op;
    logic        wr_en;
    logic        bit_ok;
    logic        op_ok;
    logic [PW-1:0] bmask;
    logic        unused_wbits;

    assign op           = bus_op_e'(bus_op);
    assign wr_en        = bus_sel && bus_wr;
    assign bit_ok       = bus_bit < PW_IDX;
    assign op_ok        = (op == OP_LOAD) || (((op == OP_SET) || (op == OP_CLR)) && bit_ok);
    assign bmask        = PW'(1) << bus_bit;
    assign unused_wbits = ^bus_wdata[REG_W-1:PW];

    function automatic logic [PW-1:0] modify(input logic [PW-1:0] base,
                                             input bus_op_e o,
                                             input logic [PW-1:0] m,
                                             input logic [PW-1:0] data);
        unique case (o)
            OP_LOAD: modify = data;
            OP_SET:  modify = base | m;
            OP_CLR:  modify = base & ~m;
            OP_NONE: modify = base;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '1;
            ana_q   <= ANA_LOW4;
        end else if (wr_en && op_ok) begin
            unique case (bus_addr)
                ADDR_PORT: latch_q <= modify(port_rd, op, bmask, bus_wdata[PW-1:0]);
                ADDR_DIR:  dir_q   <= modify(dir_q, op, bmask, bus_wdata[PW-1:0]);
                ADDR_ANA:  if (op == OP_LOAD) ana_q <= ana_mode_e'(bus_wdata[1:0]);
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_PORT: bus_rdata[PW-1:0] = port_rd;
            ADDR_DIR:  bus_rdata[PW-1:0] = dir_q;
            ADDR_ANA:  bus_rdata[1:0]    = ana_q;
            default:   bus_rdata = '0;
        endcase
    end

    assert_port_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_PORT && op == OP_LOAD)
        |=> latch_q == $past(bus_wdata[PW-1:0]));

    assert_port_set_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_PORT && op == OP_SET && bit_ok)
        |=> (latch_q & $past(bmask)) == $past(bmask));

    assert_dir_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_DIR) |-> bus_rdata[REG_W-1:PW] == '0);

    assert_dir_bad_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_DIR && op != OP_LOAD && !bit_ok)
        |=> $stable(dir_q));

    assert_ana_bitop_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_ANA && op != OP_LOAD) |=> $stable(ana_q));
endmodule

// File: rtl/gpio5_drive.sv
module gpio5_drive
    import gpio5_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic [PW-1:0] latch_q,
    input  logic [PW-1:0] dir_q,
    input  ana_mode_e     ana_q,
    input  logic [PW-1:0] pin_sync,
    output logic [PW-1:0] pad_out,
    output logic [PW-1:0] pad_oe,
    output logic [PW-1:0] port_rd,
    output logic          tmr_clk
);
    localparam int OD_BIT = PW - 1;

    logic [ANA_W-1:0] amask;
    assign amask = ana_mask(ana_q);

    for (genvar i = 0; i < PW; i++) begin : g_bit
        if (i == OD_BIT) begin : g_od
            assign pad_out[i] = 1'b0;
            assign pad_oe[i]  = ~dir_q[i] & ~latch_q[i];
        end else begin : g_pp
            assign pad_out[i] = latch_q[i];
            assign pad_oe[i]  = ~dir_q[i];
        end
        if (i < ANA_W) begin : g_ana
            assign port_rd[i] = pin_sync[i] & ~amask[i];
        end else begin : g_dig
            assign port_rd[i] = pin_sync[i];
        end
    end

    assign tmr_clk = pin_sync[OD_BIT];
endmodule

// File: rtl/gpio5_port.sv
module gpio5_port
    import gpio5_pkg::*;
#(
    parameter int PW          = 5,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [1:0]               bus_addr,
    input  logic [1:0]               bus_op,
    input  logic [$clog2(REG_W)-1:0] bus_bit,
    input  logic [REG_W-1:0]         bus_wdata,
    output logic [REG_W-1:0]         bus_rdata,
    input  logic [PW-1:0]            pad_in,
    output logic [PW-1:0]            pad_out,
    output logic [PW-1:0]            pad_oe,
    output logic                     tmr_clk
);
    localparam int OD_BIT = PW - 1;

    logic [PW-1:0] pin_sync;
    logic [PW-1:0] port_rd;
    logic [PW-1:0] latch_q;
    logic [PW-1:0] dir_q;
    ana_mode_e     ana_q;

    gpio5_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    gpio5_regs #(.PW(PW), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_op    (bus_op),
        .bus_bit   (bus_bit),
        .bus_wdata (bus_wdata),
        .port_rd   (port_rd),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .ana_q     (ana_q),
        .bus_rdata (bus_rdata)
    );

    gpio5_drive #(.PW(PW)) u_drive (
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .ana_q    (ana_q),
        .pin_sync (pin_sync),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .port_rd  (port_rd),
        .tmr_clk  (tmr_clk)
    );

    assert_od_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_PORT && bus_op == OP_LOAD && bus_wdata[OD_BIT])
        |=> !pad_oe[OD_BIT]);

    assert_od_never_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_oe[OD_BIT] && pad_out[OD_BIT]));

    assert_input_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_DIR && bus_op == OP_LOAD)
        |=> ((pad_oe & $past(bus_wdata[PW-1:0])) == '0));
endmodule

// File: tb/tb_gpio5_port.sv
`timescale 1ns/1ps
module tb_gpio5_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [1:0] bus_op = 2'b11;
    logic [2:0] bus_bit = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] pad_in;
    logic [4:0] pad_out;
    logic [4:0] pad_oe;
    logic       tmr_clk;
    logic [4:0] pin_ext = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    for (genvar i = 0; i < 5; i++) begin : g_pad
        assign pad_in[i] = pad_oe[i] ? pad_out[i] : pin_ext[i];
    end

    gpio5_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_op(bus_op), .bus_bit(bus_bit),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .tmr_clk(tmr_clk)
    );

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always @(negedge clk) begin
        item_t it;
        logic [7:0] act;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {3'b0, pad_oe};
                2:       act = {3'b0, pad_out};
                default: act = {7'b0, tmr_clk};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int kind, input logic [1:0] addr,
                              input logic [7:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [1:0] addr, input logic [1:0] op,
                      input logic [2:0] idx, input logic [7:0] data);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr;
        bus_op = op; bus_bit = idx; bus_wdata = data;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_sel = 1'b0; bus_op = 2'b11;
    endtask

    task automatic wr_pin(input logic [4:0] pins, input logic [1:0] addr,
                          input logic [1:0] op, input logic [2:0] idx);
        @(posedge clk); #1;
        pin_ext = pins;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr;
        bus_op = op; bus_bit = idx; bus_wdata = '0;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_sel = 1'b0; bus_op = 2'b11;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        pin_ext = 5'b10101;
        idle(3);
        #1 rst_n = 1'b1;
        // R1 reset state
        expect_val(0, 2'd1, 8'h1F, "R1 dir reset");
        expect_val(0, 2'd2, 8'h00, "R1 analog reset");
        expect_val(1, 2'd0, 8'h00, "R1 no drive at reset");
        idle(3);
        expect_val(0, 2'd0, 8'h10, "R9 mode 00 masks pins 3..0");
        // all digital
        wr(2'd2, 2'b00, 3'd0, 8'hFF);
        expect_val(0, 2'd2, 8'h03, "R11 analog readback");
        idle(3);
        expect_val(0, 2'd0, 8'h15, "R3 pin levels");
        expect_val(3, 2'd0, 8'h01, "R7 timer clock high");
        // load latch and enable drivers
        wr(2'd0, 2'b00, 3'd0, 8'hEA);
        expect_val(1, 2'd0, 8'h00, "R2 inputs not driven");
        wr(2'd1, 2'b00, 3'd0, 8'hE0);
        expect_val(0, 2'd1, 8'h00, "R8 upper dir bits ignored");
        expect_val(1, 2'd0, 8'h1F, "R2 R6 all driven");
        expect_val(2, 2'd0, 8'h0A, "R4 latch drives pads");
        idle(3);
        expect_val(3, 2'd0, 8'h00, "R7 timer clock follows pulled-low pin");
        wr(2'd0, 2'b00, 3'd0, 8'h1F);
        expect_val(1, 2'd0, 8'h0F, "R6 open-drain released");
        expect_val(2, 2'd0, 8'h0F, "R6 open-drain never drives high");
        // read-modify-write from pins
        wr(2'd1, 2'b00, 3'd0, 8'hFF);
        pin_ext = 5'b00110;
        idle(3);
        wr(2'd0, 2'b01, 3'd0, 8'h00);
        wr(2'd1, 2'b00, 3'd0, 8'h00);
        expect_val(2, 2'd0, 8'h07, "R5 set uses pin levels");
        expect_val(1, 2'd0, 8'h1F, "R6 open-drain pulls low");
        // direction bit operations
        wr(2'd1, 2'b01, 3'd2, 8'h00);
        expect_val(0, 2'd1, 8'h04, "R10 dir bit set");
        wr(2'd1, 2'b01, 3'd6, 8'h00);
        expect_val(0, 2'd1, 8'h04, "R10 out-of-range index");
        wr(2'd1, 2'b10, 3'd2, 8'h00);
        expect_val(0, 2'd1, 8'h00, "R10 dir bit clear");
        // analog modes
        wr(2'd2, 2'b00, 3'd0, 8'h01);
        idle(3);
        expect_val(0, 2'd0, 8'h04, "R9 mode 01");
        expect_val(1, 2'd0, 8'h1F, "R9 direction governs analog pins");
        wr(2'd2, 2'b00, 3'd0, 8'h02);
        expect_val(0, 2'd0, 8'h06, "R9 mode 10");
        wr(2'd2, 2'b01, 3'd0, 8'h00);
        expect_val(0, 2'd2, 8'h02, "R11 bit op on mode ignored");
        wr(2'd2, 2'b00, 3'd0, 8'h00);
        expect_val(0, 2'd0, 8'h00, "R9 mode 00");
        // unused address and no-op
        wr(2'd3, 2'b00, 3'd0, 8'hFF);
        expect_val(0, 2'd3, 8'h00, "R11 address 3 reads zero");
        expect_val(0, 2'd1, 8'h00, "R11 address 3 write ignored");
        wr(2'd1, 2'b11, 3'd0, 8'hFF);
        expect_val(0, 2'd1, 8'h00, "R11 op 11 writes nothing");
        // bit op in the same cycle as a pad change
        wr(2'd2, 2'b00, 3'd0, 8'h03);
        wr(2'd1, 2'b00, 3'd0, 8'hFF);
        pin_ext = 5'b00000;
        idle(3);
        expect_val(0, 2'd0, 8'h00, "R3 all low");
        wr_pin(5'b01000, 2'd0, 2'b01, 3'd0);
        idle(3);
        expect_val(0, 2'd0, 8'h08, "R3 new level after sync");
        wr(2'd1, 2'b00, 3'd0, 8'h00);
        expect_val(2, 2'd0, 8'h01, "R5 R3 bit op takes older sampled level");
        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule